// File: doc/BRIEF.md
# Keypad Nibble Scanner for Dual-Tone Step Selection

The scanner reads a 4x4 key matrix through one 8-bit bidirectional port. For each port bit it supplies a direction and a drive value: a 1 in `pin_dir` makes the bit an output that carries `pin_drive`. A 0 in `pin_dir` makes the bit an input, and `pin_drive` then turns its pull-up on. The scanner alternates between two phases without end. In the row phase the four low bits are driven to zero and the four high bits are read with pull-ups. In the column phase the two nibbles swap roles.

Each phase lasts a fixed number of clock cycles, given as a parameter, so that the lines can settle. In the last cycle of a phase the scanner finds the first low bit of the nibble being read, starting from the most significant bit. It turns that position into a phase-increment step for a tone synthesizer. Row lines select the low tone group and column lines select the high tone group. A step value of zero means that no key was seen.

Both steps are registered, and each changes only when its own phase ends. A single-cycle strobe marks the point at which a complete row-and-column pair is ready for the synthesizer.

Top module: `kp_nibble_scanner`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `row_step`, `col_step` and `step_strobe` are 0, `pin_dir` is 0x0F and `pin_drive` is 0xF0.
- R2: In the row phase `pin_dir` is 0x0F (bits 3..0 are outputs) and `pin_drive` is 0xF0 (bits 3..0 driven low, pull-ups on bits 7..4).
- R3: In the column phase `pin_dir` is 0xF0 and `pin_drive` is 0x0F (bits 7..4 driven low, pull-ups on bits 3..0).
- R4: Each phase lasts SETTLE_CYCLES clock cycles and the phases alternate row, column, row and so on without end. `pin_in` is sampled only in the last cycle of each phase.
- R5: At the end of a row phase, the first zero found while scanning bit 7 down to bit 4 sets `row_step`: bit 7 gives 61, bit 6 gives 56, bit 5 gives 50 and bit 4 gives 46. Lower-priority zeros are ignored.
- R6: At the end of a column phase, the first zero found while scanning bit 3 down to bit 0 sets `col_step`: bit 3 gives 107, bit 2 gives 96, bit 1 gives 87 and bit 0 gives 79.
- R7: If the nibble being read has no zero bit, the matching step output becomes 0.
- R8: `row_step` changes only on the clock edge that ends a row phase, and `col_step` changes only on the edge that ends a column phase. The new value is visible from the first cycle of the next phase.
- R9: `step_strobe` is high for exactly one cycle: the first cycle after each column phase ends.
- R10: Bits of `pin_in` outside the nibble being read have no effect. In the column phase the driven-low bits 7..4 never produce a column step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 8 | Sensed levels of the eight port lines |
| pin_dir | output | 8 | Per-bit direction, 1 = output |
| pin_drive | output | 8 | Output value for outputs, pull-up enable for inputs |
| row_step | output | 8 | Low-group tone step, 0 = no row key |
| col_step | output | 8 | High-group tone step, 0 = no column key |
| step_strobe | output | 1 | One-cycle pulse after each column phase |

## Verification
The hardest cases to reach are those where priority decides the result. One case is several keys closed at once on the same column or the same row, so that more than one line of the sensed nibble is low. The other is a key that changes inside a phase, just before or just after the sampling cycle. The bench models the matrix electrically: a closed key pulls its undriven line low when the line on its other side is driven to zero. The bench presses key pairs that share a line and the full matrix, and it releases a key a few cycles into a phase. A per-cycle reference model then predicts which phase end captures each state.

// File: rtl/kp_scan_pkg.sv
package kp_scan_pkg;

    localparam int unsigned KP_LINES  = 4;
    localparam int unsigned KP_PORT_W = 2 * KP_LINES;
    localparam int unsigned KP_STEP_W = 8;
    localparam int unsigned KP_RANK_W = $clog2(KP_LINES);

    typedef logic [KP_STEP_W-1:0] step_t;
    typedef logic [KP_LINES-1:0]  nib_t;
    typedef logic [KP_PORT_W-1:0] port_t;

    // Which half of the port is being sensed.
    typedef enum logic {
        PH_ROW = 1'b0,
        PH_COL = 1'b1
    } scan_phase_e;

    // Tone group a lookup instance serves.
    typedef enum logic {
        TBL_ROW = 1'b0,
        TBL_COL = 1'b1
    } tone_group_e;

    // Port configuration: dir=1 drives drv, dir=0 uses drv as pull-up enable.
    typedef struct packed {
        port_t dir;
        port_t drv;
    } port_cfg_t;

    // Result of the priority search: hit flag and rank (0 = MSB of nibble).
    typedef struct packed {
        logic                 hit;
        logic [KP_RANK_W-1:0] rank;
    } prio_t;

    // Scan from the most significant line down; first low line wins.
    function automatic prio_t first_low(input nib_t lines);
        prio_t res;
        res = '0;
        for (int i = 0; i < KP_LINES; i++) begin
            if (!res.hit && !lines[KP_LINES-1-i]) begin
                res.hit  = 1'b1;
                res.rank = KP_RANK_W'(i);
            end
        end
        return res;
    endfunction

    // Phase-increment steps indexed by priority rank.
    function automatic step_t tone_step(input tone_group_e grp,
                                        input logic [KP_RANK_W-1:0] rank);
        step_t s;
        s = '0;
        if (grp == TBL_ROW) begin
            case (rank)
                2'd0:    s = 8'd61;
                2'd1:    s = 8'd56;
                2'd2:    s = 8'd50;
                default: s = 8'd46;
            endcase
        end else begin
            case (rank)
                2'd0:    s = 8'd107;
                2'd1:    s = 8'd96;
                2'd2:    s = 8'd87;
                default: s = 8'd79;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/kp_settle_timer.sv
module kp_settle_timer #(
    parameter int unsigned SETTLE_CYCLES = 10
) (
    input  logic clk,
    input  logic rst,
    output logic done
);

    localparam int unsigned CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt == LAST);

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    // R4
    settle_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (cnt == '0));

endmodule

// File: rtl/kp_port_ctrl.sv
module kp_port_ctrl
    import kp_scan_pkg::*;
(
    input  scan_phase_e phase,
    output port_cfg_t   cfg
);

    // Lower half: output-low in row phase, pulled-up input in column phase.
    // Upper half: the mirror image.
    for (genvar i = 0; i < KP_LINES; i++) begin : g_line
        always_comb begin
            cfg.dir[i]            = (phase == PH_ROW);
            cfg.drv[i]            = (phase == PH_COL);
            cfg.dir[i + KP_LINES] = (phase == PH_COL);
            cfg.drv[i + KP_LINES] = (phase == PH_ROW);
        end
    end

endmodule

// File: rtl/kp_prio_lookup.sv
module kp_prio_lookup
    import kp_scan_pkg::*;
#(
    parameter tone_group_e GROUP = TBL_ROW
) (
    input  nib_t  lines,
    output step_t step
);

    prio_t found;

    always_comb begin
        found = first_low(lines);
        step  = found.hit ? tone_step(GROUP, found.rank) : '0;
    end

endmodule

// File: rtl/kp_nibble_scanner.sv
module kp_nibble_scanner
    import kp_scan_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [KP_PORT_W-1:0] pin_in,
    output logic [KP_PORT_W-1:0] pin_dir,
    output logic [KP_PORT_W-1:0] pin_drive,
    output logic [KP_STEP_W-1:0] row_step,
    output logic [KP_STEP_W-1:0] col_step,
    output logic                 step_strobe
);

    scan_phase_e phase;
    logic        tmr_done;
    port_cfg_t   cfg;
    step_t       row_next;
    step_t       col_next;

    kp_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .done (tmr_done)
    );

    kp_port_ctrl u_port (
        .phase (phase),
        .cfg   (cfg)
    );

    assign pin_dir   = cfg.dir;
    assign pin_drive = cfg.drv;

    kp_prio_lookup #(.GROUP(TBL_ROW)) u_row_lut (
        .lines (pin_in[KP_PORT_W-1:KP_LINES]),
        .step  (row_next)
    );

    kp_prio_lookup #(.GROUP(TBL_COL)) u_col_lut (
        .lines (pin_in[KP_LINES-1:0]),
        .step  (col_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= PH_ROW;
            row_step    <= '0;
            col_step    <= '0;
            step_strobe <= 1'b0;
        end else begin
            step_strobe <= 1'b0;
            if (tmr_done) begin
                case (phase)
                    PH_ROW: begin
                        row_step <= row_next;
                        phase    <= PH_COL;
                    end
                    default: begin
                        col_step    <= col_next;
                        phase       <= PH_ROW;
                        step_strobe <= 1'b1;
                    end
                endcase
            end
        end
    end

    // R4
    phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(pin_dir) |-> $past(tmr_done));

    // R8
    row_update_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(row_step) |-> ($past(tmr_done) && $past(phase) == PH_ROW));

    // R8
    col_update_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(col_step) |-> ($past(tmr_done) && $past(phase) == PH_COL));

    // R9
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        step_strobe |=> !step_strobe);

    // R9
    strobe_origin_chk: assert property (@(posedge clk) disable iff (rst)
        step_strobe |-> ($past(phase) == PH_COL && phase == PH_ROW));

    // R5
    row_legal_chk: assert property (@(posedge clk) disable iff (rst)
        row_step inside {8'd0, 8'd46, 8'd50, 8'd56, 8'd61});

    // R6
    col_legal_chk: assert property (@(posedge clk) disable iff (rst)
        col_step inside {8'd0, 8'd79, 8'd87, 8'd96, 8'd107});

endmodule

// File: tb/tb_kp_nibble_scanner.sv
`timescale 1ns/1ps
module tb_kp_nibble_scanner;

    localparam int S = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pin_in;
    logic [7:0] pin_dir;
    logic [7:0] pin_drive;
    logic [7:0] row_step;
    logic [7:0] col_step;
    logic       step_strobe;

    logic [15:0] keys = '0;   // key index r*4+c; row r on bit 7-r, column c on bit 3-c

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    kp_nibble_scanner #(.SETTLE_CYCLES(S)) dut (
        .clk         (clk),
        .rst         (rst),
        .pin_in      (pin_in),
        .pin_dir     (pin_dir),
        .pin_drive   (pin_drive),
        .row_step    (row_step),
        .col_step    (col_step),
        .step_strobe (step_strobe)
    );

    // Electrical model of the matrix: pull-ups, driven lines, key closures.
    function automatic logic [7:0] matrix_pins(input logic [7:0] d, input logic [7:0] o,
                                               input logic [15:0] k);
        logic [7:0] p;
        p = o;
        for (int r = 0; r < 4; r++) begin
            for (int c = 0; c < 4; c++) begin
                if (k[r*4+c]) begin
                    if (d[3-c] && !o[3-c] && !d[7-r]) p[7-r] = 1'b0;
                    if (d[7-r] && !o[7-r] && !d[3-c]) p[3-c] = 1'b0;
                end
            end
        end
        return p;
    endfunction

    always_comb pin_in = matrix_pins(pin_dir, pin_drive, keys);

    function automatic int expect_step(input logic [3:0] nib, input bit is_row);
        int row_tab [4] = '{61, 56, 50, 46};
        int col_tab [4] = '{107, 96, 87, 79};
        for (int b = 3; b >= 0; b--) begin
            if (!nib[b]) return is_row ? row_tab[3-b] : col_tab[3-b];
        end
        return 0;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model, advanced on every rising edge.
    int         t       = 0;
    int         exp_row = 0;
    int         exp_col = 0;
    bit         exp_stb = 0;
    bit         started = 0;
    logic [7:0] pins_q  = 8'hFF;

    always @(posedge clk) begin
        if (rst) begin
            t = 0; exp_row = 0; exp_col = 0; exp_stb = 0; started = 1;
        end else if (started) begin
            // R4: phase of length S, sample in its last cycle, row first
            exp_stb = 0;
            if (t % S == S - 1) begin
                if (((t / S) % 2) == 0) exp_row = expect_step(pins_q[7:4], 1'b1);
                else begin
                    exp_col = expect_step(pins_q[3:0], 1'b0);   // R10: high nibble ignored
                    exp_stb = 1;
                end
            end
            t++;
        end
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        pins_q = pin_in;
        if (started) begin
            bit   rowph;
            logic [7:0] ed;
            rowph = ((t / S) % 2) == 0;
            ed    = rowph ? 8'h0F : 8'hF0;
            check(pin_dir == ed,    rowph ? "R2 dir" : "R3 dir", pin_dir, ed);
            check(pin_drive == ~ed, rowph ? "R2 drive" : "R3 drive", pin_drive, ~ed);
            check(row_step == exp_row, "R5 R7 R8 row_step", row_step, exp_row);
            check(col_step == exp_col, "R6 R7 R8 col_step", col_step, exp_col);
            check(step_strobe == exp_stb, "R9 strobe", step_strobe, exp_stb);
        end
    end

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_keys(input logic [15:0] k);
        @(posedge clk);
        #1 keys = k;
    endtask

    initial begin
        // R1: reset state
        rst = 1'b1;
        run(4);
        @(negedge clk);
        check(row_step == 0 && col_step == 0 && step_strobe == 0, "R1 outputs", row_step, 0);
        check(pin_dir == 8'h0F && pin_drive == 8'hF0, "R1 port", pin_dir, 8'h0F);
        @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(row_step == 0 && step_strobe == 0, "R1 after release", row_step, 0);

        // R7, R10: no key pressed
        run(6 * S);

        // R5, R6: every single key
        for (int r = 0; r < 4; r++) begin
            for (int c = 0; c < 4; c++) begin
                set_keys(16'(1) << (r * 4 + c));
                run(4 * S + 3);
            end
        end

        // R5: two keys on one column, higher row bit wins
        set_keys((16'(1) << (1 * 4 + 2)) | (16'(1) << (3 * 4 + 2)));
        run(4 * S);
        // R6: two keys on one row
        set_keys((16'(1) << (2 * 4 + 1)) | (16'(1) << (2 * 4 + 3)));
        run(4 * S);
        // R5 R6: whole matrix
        set_keys(16'hFFFF);
        run(4 * S);

        // R8: key released mid-phase, captured only at phase end
        set_keys(16'(1) << 5);
        run(S + 3);
        set_keys('0);
        run(S / 2);
        set_keys(16'(1) << 10);
        run(3 * S + 1);

        // R1: reset during activity with a key held
        @(posedge clk);
        #1 rst = 1'b1;
        run(3);
        rst = 1'b0;
        run(4 * S);
        set_keys('0);
        run(3 * S);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule